// File: doc/BRIEF.md
# Virtual Output Queue Maximum Weight Crossbar Scheduler

This block is the central arbiter of a small N-by-N input-queued cell switch. Every input keeps one logical queue per output, so a cell bound for a busy output never stalls cells bound elsewhere. The scheduler tracks how many cells wait in each of these N*N queues, and on request computes a crossbar configuration: a one-to-one pairing of inputs to outputs that carries the largest total number of waiting cells. Picking the heaviest pairing rather than any maximal one is what allows such a switch to sustain full throughput under admissible traffic, where a single-FIFO-per-input design tops out near 58 percent.

Arrivals are reported one per input per cycle as a destination index. A scheduling round starts with a pulse on `slot_start`: the FSM leaves IDLE, copies every occupancy counter into a frozen weight snapshot and enters SCAN. SCAN visits all N! pairings, one per cycle, in ascending lexicographic order of the output list assigned to inputs 0..N-1, keeping the heaviest one seen. After the last pairing the FSM moves to GRANT, which publishes the winner on registered outputs, pulses `match_done`, retires one cell from every granted queue, and returns to IDLE. Pairs whose snapshot weight is zero are never granted.

Top module: `voq_mwm_sched`

## Requirements
- R1: An arrival with `arr_valid[i]`=1 and `arr_dest[i]`=j raises the occupancy of queue (i,j) by one; each such cell is granted exactly once in later rounds.
- R2: An occupancy counter holds at its maximum 2^CW-1 when further arrivals come in; with CW=4 a queue fed 20 cells is granted exactly 15 times.
- R3: A granted queue loses one cell at the edge that raises `match_done`; an arrival to that same queue at that same edge leaves its count unchanged.
- R4: A `slot_start` seen in IDLE makes `busy` high for the next N!+1 cycles and raises `match_done` for exactly one cycle at the edge that ends them (25 cycles after the start edge for N=4).
- R5: `slot_start` while `busy` is high is ignored: it neither restarts nor extends the round.
- R6: The published pairing maximizes the sum, over its pairs, of the occupancies captured at the start edge.
- R7: Among pairings of equal total weight, the one with the lowest lexicographic rank wins (identity 0,1,2,3 has rank 0).
- R8: An input whose chosen pair has zero captured weight gets `match_valid[i]`=0 and `match_port[i]`=0.
- R9: No two valid inputs are ever given the same output.
- R10: After reset all outputs are zero; `match_valid` and `match_port` change only at the edge that raises `match_done` and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| arr_valid | input | N | Per-input cell arrival this cycle |
| arr_dest | input | N*log2(N) | Per-input destination output, input i in bits [i*IW +: IW] |
| slot_start | input | 1 | Begin a scheduling round (taken only in IDLE) |
| busy | output | 1 | High in SCAN and GRANT |
| match_done | output | 1 | One-cycle pulse when a new pairing is published |
| match_valid | output | N | Input i is connected this round |
| match_port | output | N*log2(N) | Output assigned to input i, bits [i*IW +: IW] |

## Verification
The start edge freezes the weights, so the pairing published 25 cycles later (N=4) must match a model evaluated on the counts held just before that edge, and the decrement lands on the same edge as `match_done`. The bench model steps on every rising edge with the same inputs, counting down N!+1 edges before it publishes its own brute-force best pairing, and every output is compared on the falling edge that follows, so each result is sampled in the cycle it is due. Directed rounds then compare published pairings against hand-worked values read in the cycle after `match_done` rises.

// File: rtl/voq_sched_pkg.sv
package voq_sched_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SCAN  = 2'd1,
        S_GRANT = 2'd2
    } sched_state_e;

    function automatic int fact(input int n);
        int r;
        r = 1;
        for (int i = 2; i <= n; i++) r = r * i;
        return r;
    endfunction

endpackage

// File: rtl/voq_occupancy.sv
module voq_occupancy #(
    parameter int N  = 4,
    parameter int CW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N*N-1:0]    inc,
    input  logic [N*N-1:0]    dec,
    output logic [N*N*CW-1:0] occ
);
    localparam logic [CW-1:0] CMAX = '1;

    for (genvar e = 0; e < N*N; e++) begin : g_cell
        logic [CW-1:0] c;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                c <= '0;
            else if (inc[e] && !dec[e] && c != CMAX)
                c <= c + CW'(1);
            else if (dec[e] && !inc[e])
                c <= c - CW'(1);
        end

        assign occ[e*CW +: CW] = c;

        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (c == CMAX && inc[e] && !dec[e]) |=> c == CMAX); // R2
        AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            dec[e] |-> c != '0); // R3
    end

endmodule

// File: rtl/voq_perm_gen.sv
module voq_perm_gen
    import voq_sched_pkg::*;
#(
    parameter int N  = 4,
    parameter int KW = 5,
    parameter int IW = 2
) (
    input  logic [KW-1:0]   idx,
    output logic [N*IW-1:0] perm
);
    // Rank to permutation through factorial digits, lexicographic order.
    always_comb begin
        int rem;
        int d;
        int cnt;
        logic [N-1:0] used;
        logic found;
        perm = '0;
        used = '0;
        rem  = int'(idx);
        for (int i = 0; i < N; i++) begin
            d     = rem / fact(N-1-i);
            rem   = rem % fact(N-1-i);
            cnt   = 0;
            found = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (!used[j] && !found) begin
                    if (cnt == d) begin
                        found   = 1'b1;
                        used[j] = 1'b1;
                        perm[i*IW +: IW] = IW'(j);
                    end
                    cnt = cnt + 1;
                end
            end
        end
    end

endmodule

// File: rtl/voq_mwm_sched.sv
module voq_mwm_sched
    import voq_sched_pkg::*;
#(
    parameter int N  = 4,
    parameter int CW = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N-1:0]             arr_valid,
    input  logic [N*$clog2(N)-1:0]   arr_dest,
    input  logic                     slot_start,
    output logic                     busy,
    output logic                     match_done,
    output logic [N-1:0]             match_valid,
    output logic [N*$clog2(N)-1:0]   match_port
);
    localparam int IW    = $clog2(N);
    localparam int NPERM = fact(N);
    localparam int KW    = (NPERM > 1) ? $clog2(NPERM) : 1;
    localparam int SW    = CW + $clog2(N);
    localparam logic [KW-1:0] KLAST = KW'(NPERM - 1);

    sched_state_e       state_q, state_d;
    logic [KW-1:0]      k_q, best_k_q;
    logic [SW-1:0]      best_w_q, scan_w;
    logic [N*N*CW-1:0]  snap_q, occ;
    logic [N*IW-1:0]    scan_perm, win_perm, win_port;
    logic [N-1:0]       grant_v;
    logic [N*N-1:0]     inc_m, dec_m;

    voq_occupancy #(.N(N), .CW(CW)) u_occ (
        .clk(clk), .rst_n(rst_n), .inc(inc_m), .dec(dec_m), .occ(occ)
    );

    voq_perm_gen #(.N(N), .KW(KW), .IW(IW)) u_scan (
        .idx(k_q), .perm(scan_perm)
    );

    voq_perm_gen #(.N(N), .KW(KW), .IW(IW)) u_win (
        .idx(best_k_q), .perm(win_perm)
    );

    // Arrival decode
    always_comb begin
        inc_m = '0;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                inc_m[i*N + j] = arr_valid[i] && (arr_dest[i*IW +: IW] == IW'(j));
    end

    // Weight of the pairing under evaluation
    always_comb begin
        scan_w = '0;
        for (int i = 0; i < N; i++)
            scan_w = scan_w + SW'(snap_q[(i*N + int'(scan_perm[i*IW +: IW]))*CW +: CW]);
    end

    // Winner masking and departures
    always_comb begin
        grant_v  = '0;
        win_port = '0;
        dec_m    = '0;
        for (int i = 0; i < N; i++) begin
            if (snap_q[(i*N + int'(win_perm[i*IW +: IW]))*CW +: CW] != '0) begin
                grant_v[i] = 1'b1;
                win_port[i*IW +: IW] = win_perm[i*IW +: IW];
                if (state_q == S_GRANT)
                    dec_m[i*N + int'(win_perm[i*IW +: IW])] = 1'b1;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (slot_start) state_d = S_SCAN;
            S_SCAN:  if (k_q == KLAST) state_d = S_GRANT;
            S_GRANT: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Search datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q   <= '0;
            k_q      <= '0;
            best_w_q <= '0;
            best_k_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (slot_start) begin
                    snap_q   <= occ;
                    k_q      <= '0;
                    best_w_q <= '0;
                    best_k_q <= '0;
                end
                S_SCAN: begin
                    k_q <= k_q + KW'(1);
                    if (scan_w > best_w_q) begin
                        best_w_q <= scan_w;
                        best_k_q <= k_q;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_done  <= 1'b0;
            match_valid <= '0;
            match_port  <= '0;
        end else begin
            match_done <= (state_q == S_GRANT);
            if (state_q == S_GRANT) begin
                match_valid <= grant_v;
                match_port  <= win_port;
            end
        end
    end

    assign busy = (state_q != S_IDLE);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        match_done |=> !match_done); // R4
    AST_HOLD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !match_done |-> ($stable(match_valid) && $stable(match_port))); // R10
    AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(snap_q)); // R5

    for (genvar a = 0; a < N; a++) begin : g_pa
        for (genvar b = a + 1; b < N; b++) begin : g_pb
            AST_NO_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
                (match_valid[a] && match_valid[b]) |->
                (match_port[a*IW +: IW] != match_port[b*IW +: IW])); // R9
        end
    end

endmodule

// File: tb/voq_mwm_sched_test.sv
`timescale 1ns/1ps
module voq_mwm_sched_test;
    localparam int N     = 4;
    localparam int CW    = 4;
    localparam int IW    = 2;
    localparam int NPERM = 24;
    localparam int CMAX  = 15;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    arr_valid = '0;
    logic [N*IW-1:0] arr_dest = '0;
    logic            slot_start = 1'b0;
    logic            busy, match_done;
    logic [N-1:0]    match_valid;
    logic [N*IW-1:0] match_port;

    int total = 0;
    int bad   = 0;

    voq_mwm_sched #(.N(N), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_dest(arr_dest),
        .slot_start(slot_start), .busy(busy), .match_done(match_done),
        .match_valid(match_valid), .match_port(match_port)
    );

    always #2.5 clk = ~clk;

    // Reference model state
    int m_cnt  [N][N];
    int m_snap [N][N];
    int m_rem;
    int m_done;
    int m_valid[N];
    int m_port [N];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_match();
        int p[N];
        int best[N];
        int bw, w, a, b, t;
        for (int i = 0; i < N; i++) begin p[i] = i; best[i] = i; end
        bw = -1;
        while (1) begin
            w = 0;
            for (int i = 0; i < N; i++) w += m_snap[i][p[i]];
            if (w > bw) begin
                bw = w;
                for (int i = 0; i < N; i++) best[i] = p[i];
            end
            a = -1;
            for (int i = 0; i < N-1; i++) if (p[i] < p[i+1]) a = i;
            if (a < 0) break;
            b = a + 1;
            for (int j = a + 1; j < N; j++) if (p[j] > p[a]) b = j;
            t = p[a]; p[a] = p[b]; p[b] = t;
            for (int lo = a + 1, hi = N - 1; lo < hi; lo++, hi--) begin
                t = p[lo]; p[lo] = p[hi]; p[hi] = t;
            end
        end
        for (int i = 0; i < N; i++) begin
            m_valid[i] = (m_snap[i][best[i]] != 0) ? 1 : 0;
            m_port[i]  = (m_valid[i] != 0) ? best[i] : 0;
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin m_cnt[i][j] = 0; m_snap[i][j] = 0; end
                m_valid[i] = 0; m_port[i] = 0;
            end
            m_rem = 0; m_done = 0;
        end else begin
            int dec[N][N];
            for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) dec[i][j] = 0;
            m_done = 0;
            if (m_rem == 0) begin
                if (slot_start) begin
                    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) m_snap[i][j] = m_cnt[i][j];
                    m_rem = NPERM + 1;
                end
            end else begin
                m_rem--;
                if (m_rem == 0) begin
                    model_match();
                    m_done = 1;
                    for (int i = 0; i < N; i++) if (m_valid[i] != 0) dec[i][m_port[i]] = 1;
                end
            end
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    int inc;
                    inc = (arr_valid[i] && int'(arr_dest[i*IW +: IW]) == j) ? 1 : 0;
                    if (inc == 1 && dec[i][j] == 0 && m_cnt[i][j] < CMAX) m_cnt[i][j]++;
                    else if (dec[i][j] == 1 && inc == 0) m_cnt[i][j]--;
                end
            end
        end
    end

    // Per-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == (m_rem != 0), "R4 busy", int'(busy), int'(m_rem != 0));
            chk(int'(match_done) == m_done, "R4 done", int'(match_done), m_done);
            for (int i = 0; i < N; i++) begin
                chk(int'(match_valid[i]) == m_valid[i], "R6/R8 valid", int'(match_valid[i]), m_valid[i]);
                chk(int'(match_port[i*IW +: IW]) == m_port[i], "R6/R7 port", int'(match_port[i*IW +: IW]), m_port[i]);
                for (int j = i + 1; j < N; j++)
                    if (match_valid[i] && match_valid[j])
                        chk(match_port[i*IW +: IW] != match_port[j*IW +: IW], "R9 conflict",
                            int'(match_port[j*IW +: IW]), -1);
            end
        end
    end

    task automatic push(input int i, input int j);
        @(negedge clk);
        arr_valid = '0;
        arr_valid[i] = 1'b1;
        arr_dest[i*IW +: IW] = IW'(j);
        slot_start = 1'b0;
        @(negedge clk);
        arr_valid = '0;
    endtask

    // Start a round, optionally add an arrival at the publishing edge
    task automatic run_slot(input bit late_arr, input int li, input int lj);
        @(negedge clk);
        arr_valid = '0;
        slot_start = 1'b1;
        @(negedge clk);
        slot_start = 1'b0;
        repeat (NPERM) @(negedge clk);
        if (late_arr) begin
            arr_valid[li] = 1'b1;
            arr_dest[li*IW +: IW] = IW'(lj);
        end
        @(negedge clk);
        arr_valid = '0;
    endtask

    task automatic expect_m(input int i, input int v, input int p, input string req);
        chk(int'(match_valid[i]) == v, req, int'(match_valid[i]), v);
        if (v != 0) chk(int'(match_port[i*IW +: IW]) == p, req, int'(match_port[i*IW +: IW]), p);
    endtask

    task automatic drain();
        for (int n = 0; n < 40; n++) begin
            run_slot(1'b0, 0, 0);
            if (match_valid == '0) break;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int grants;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset values
        chk(!busy && !match_done, "R10 reset ctl", int'(busy), 0);
        chk(match_valid == '0 && match_port == '0, "R10 reset match", int'(match_valid), 0);

        // R8: empty queues give no grants
        run_slot(1'b0, 0, 0);
        chk(match_done == 1'b1, "R4 done due", int'(match_done), 1);
        for (int i = 0; i < N; i++) expect_m(i, 0, 0, "R8 empty");
        @(negedge clk);
        chk(match_done == 1'b0, "R4 done one cycle", int'(match_done), 0);

        // R6: heaviest pairing beats the greedy choice
        repeat (5) push(0, 0);
        repeat (4) push(0, 1);
        repeat (4) push(1, 0);
        run_slot(1'b0, 0, 0);
        expect_m(0, 1, 1, "R6 heavy");
        expect_m(1, 1, 0, "R6 heavy");
        expect_m(2, 0, 0, "R8 idle input");
        expect_m(3, 0, 0, "R8 idle input");
        repeat (5) @(negedge clk);
        chk(match_valid == 4'b0011, "R10 hold", int'(match_valid), 3);
        drain();

        // R7: equal weights, lowest rank (identity) wins
        push(0, 0); push(0, 1); push(1, 0); push(1, 1);
        run_slot(1'b0, 0, 0);
        expect_m(0, 1, 0, "R7 tie");
        expect_m(1, 1, 1, "R7 tie");
        run_slot(1'b0, 0, 0);
        expect_m(0, 1, 1, "R3 depart");
        expect_m(1, 1, 0, "R3 depart");
        drain();

        // R3: arrival at the publishing edge cancels the departure
        push(2, 3); push(2, 3);
        run_slot(1'b1, 2, 3);
        expect_m(2, 1, 3, "R3 same edge");
        run_slot(1'b0, 0, 0);
        expect_m(2, 1, 3, "R3 count kept");
        run_slot(1'b0, 0, 0);
        expect_m(2, 1, 3, "R3 count kept");
        run_slot(1'b0, 0, 0);
        expect_m(2, 0, 0, "R3 emptied");

        // R1 and R2: saturation at 15 cells
        repeat (20) push(3, 2);
        grants = 0;
        for (int s = 0; s < 16; s++) begin
            run_slot(1'b0, 0, 0);
            if (match_valid[3] && match_port[3*IW +: IW] == 2'd2) grants++;
        end
        chk(grants == CMAX, "R2 saturate R1 count", grants, CMAX);

        // R5: start pulses while busy are ignored
        push(1, 2);
        @(negedge clk);
        slot_start = 1'b1;
        @(negedge clk);
        repeat (8) @(negedge clk);
        repeat (NPERM - 8) @(negedge clk);
        slot_start = 1'b0;
        @(negedge clk);
        chk(match_done == 1'b1, "R5 no restart", int'(match_done), 1);
        expect_m(1, 1, 2, "R5 match");
        @(negedge clk);
        chk(busy == 1'b0, "R5 no extension", int'(busy), 0);

        // Random traffic, checked every cycle against the model
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            arr_valid  = N'($urandom);
            arr_dest   = (N*IW)'($urandom);
            slot_start = ($urandom % 3 == 0);
        end
        @(negedge clk);
        arr_valid = '0;
        slot_start = 1'b0;
        repeat (NPERM + 4) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule